// File: doc/BRIEF.md
# Flash End-of-Write Status Reporter

This block supplies the byte that a flash bank puts on its data bus while an internal program or erase runs in the background. A one-cycle start pulse, taken together with the operation type and the byte being programmed, arms a busy timer. The timer runs for a parameterized number of clock cycles, with separate lengths for program and for erase. While the timer runs, every read returns a status byte instead of the stored contents. When the timer expires, reads show the addressed array byte unchanged.

Software polls the status byte to find the end of a write. Bit 7 holds the complement of the programmed byte's top bit during a program, and 0 during an erase. Bit 6 changes value on every new read while the operation is busy. Bits 5 to 0 carry the stored bits of the addressed location. A one-cycle done pulse marks the expiry of the timer. A start pulse that arrives while the block is busy is discarded.

Top module: `eow_status`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o and done_o are 0 and dout_o equals arr_i.
- R2: A start_i sampled high while idle raises busy_o at that clock edge. busy_o then stays high for exactly PROG_CYCLES rising edges when erase_i was 0, or ERASE_CYCLES edges when erase_i was 1.
- R3: During a program (erase_i = 0 at start), dout_o[7] is the inverse of bit 7 of wdata_i as captured at the accepted start.
- R4: During an erase (erase_i = 1 at start), dout_o[7] is 0.
- R5: While busy, dout_o[6] reads 0 for the first read after a start and changes value once for each 0-to-1 transition of rd_i. Holding rd_i high does not change it.
- R6: While busy, dout_o[5:0] equals arr_i[5:0].
- R7: done_o is high for one cycle, in the first cycle where busy_o is low after a busy period. It is low at all other times.
- R8: While not busy, dout_o equals arr_i in all eight bits. Bit 6 stops changing and bit 7 follows the array (for example 1 after an erase leaves the location at 8'hFF).
- R9: A start_i sampled while busy is ignored. It does not recapture the operation type or data, and it does not restart or extend the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse for an internal operation |
| erase_i | input | 1 | Operation type at launch: 1 erase, 0 program |
| wdata_i | input | 8 | Byte being programmed, captured at launch |
| rd_i | input | 1 | Read strobe, high while a read is in progress |
| arr_i | input | 8 | Stored byte at the addressed location |
| dout_o | output | 8 | Byte to drive on the data bus |
| busy_o | output | 1 | Internal operation in progress |
| done_o | output | 1 | One-cycle pulse when the operation ends |

## Verification
The bench runs a program for every one of the 256 data bytes and checks bit 7 against the inverted top bit, and bits 5 to 0 against a varying array byte. A design that inverts the wrong bit, or leaks the array's bit 7 into the status, fails in half of those cases. It measures the exact busy length for both operation types, so a timer that is off by one or picks the wrong length is exposed, together with the position of the done pulse. It holds the read strobe high over several cycles to catch a toggle that follows the clock rather than read edges, and it sends a second start mid-operation with the other operation type and opposite data. A design that relatches would flip bit 7 or stretch the busy window.

// File: rtl/eow_status.sv
module eow_status #(
  parameter int PROG_CYCLES  = 700,
  parameter int ERASE_CYCLES = 4500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       erase_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  input  logic [7:0] arr_i,
  output logic [7:0] dout_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW = (LONGEST > 1) ? $clog2(LONGEST) : 1;
  localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, erase_q, inv7_q, tog_q, rd_q;

  wire launch  = start_i && !busy_q;
  wire rd_edge = rd_i && !rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      erase_q <= 1'b0;
      inv7_q  <= 1'b0;
      tog_q   <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      rd_q   <= rd_i;
      done_q <= 1'b0;
      if (launch) begin
        busy_q  <= 1'b1;
        erase_q <= erase_i;
        inv7_q  <= ~wdata_i[7];
        tog_q   <= 1'b0;
        cnt_q   <= erase_i ? ERASE_LOAD : PROG_LOAD;
      end else if (busy_q) begin
        if (rd_edge) tog_q <= ~tog_q;
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  wire status7 = erase_q ? 1'b0 : inv7_q;

  assign dout_o = busy_q ? {status7, tog_q, arr_i[5:0]} : arr_i;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/eow_status_chk.sv
module eow_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       rd_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] dout_o
);
  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  p_done_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_bit7_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(dout_o[7]));

  p_toggle_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && $past(rd_i) && !$past(rd_i, 2)) |-> (dout_o[6] != $past(dout_o[6])));

  p_toggle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !($past(rd_i) && !$past(rd_i, 2))) |-> $stable(dout_o[6]));
endmodule

bind eow_status eow_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
  .busy_o(busy_o), .done_o(done_o), .dout_o(dout_o)
);

// File: tb/sim_eow_status.sv
module sim_eow_status;
  localparam int PC = 5;
  localparam int EC = 9;

  logic clk = 0, rst_n = 0, start_i = 0, erase_i = 0, rd_i = 0;
  logic [7:0] wdata_i = 0, arr_i = 0;
  logic [7:0] dout_o;
  logic busy_o, done_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  eow_status #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
    .wdata_i(wdata_i), .rd_i(rd_i), .arr_i(arr_i),
    .dout_o(dout_o), .busy_o(busy_o), .done_o(done_o));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Runs one operation; optional second start at cycle 'again' (0 = none).
  task automatic run_op(bit er, logic [7:0] d, logic [7:0] seed, int again, bit hold_rd);
    int n = 0;
    bit exp_tog = 0;
    logic [7:0] exp7;
    int want = er ? EC : PC;
    exp7 = er ? 8'h00 : {~d[7], 7'h0};
    start_i = 1; erase_i = er; wdata_i = d; rd_i = 0;
    step();
    start_i = 0;
    while (busy_o && n < 100) begin
      arr_i = seed + 8'(n * 29);
      if (hold_rd) rd_i = (n >= 1 && n <= 3);
      else rd_i = n[0];
      #0;
      if (er) chk(dout_o[7] == 1'b0, "R4", dout_o[7], 0);
      else chk(dout_o[7] == exp7[7], "R3", dout_o[7], exp7[7]);
      chk(dout_o[5:0] == arr_i[5:0], "R6", dout_o[5:0], arr_i[5:0]);
      chk(dout_o[6] == exp_tog, "R5", dout_o[6], exp_tog);
      chk(!done_o, "R7", done_o, 0);
      if (hold_rd ? (n == 1) : n[0]) exp_tog = ~exp_tog;
      if (again != 0 && n == again) begin
        start_i = 1; erase_i = ~er; wdata_i = ~d;
      end
      n++;
      step();
      start_i = 0;
    end
    rd_i = 0;
    if (again != 0) chk(n == want, "R9", n, want);
    else chk(n == want, "R2", n, want);
    chk(done_o, "R7", done_o, 1);
    arr_i = er ? 8'hFF : d;
    #0;
    chk(dout_o == arr_i, "R8", dout_o, arr_i);
    step();
    chk(!done_o && !busy_o, "R7", {done_o, busy_o}, 0);
    for (int k = 0; k < 4; k++) begin
      rd_i = k[0];
      arr_i = 8'(k * 85) ^ d;
      #0;
      chk(dout_o == arr_i, "R8", dout_o, arr_i);
      step();
    end
    rd_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    arr_i = 8'h5A;
    step(); step();
    #0;
    chk(!busy_o && !done_o, "R1", {busy_o, done_o}, 0);
    chk(dout_o == 8'h5A, "R1", dout_o, 8'h5A);
    rst_n = 1;
    #0;
    chk(!busy_o && !done_o && dout_o == arr_i, "R1", {busy_o, done_o}, 0);
    step();
    for (int d = 0; d < 256; d++) run_op(1'b0, 8'(d), 8'(d * 37 + 11), 0, 1'b0);
    for (int s = 0; s < 4; s++) run_op(1'b1, 8'(s * 64), 8'(s * 53), 0, 1'b0);
    run_op(1'b0, 8'h21, 8'h3C, 2, 1'b0);
    run_op(1'b1, 8'h00, 8'h77, 3, 1'b0);
    run_op(1'b0, 8'hC4, 8'h10, 0, 1'b1);
    run_op(1'b1, 8'h00, 8'h99, 0, 1'b1);
    summary();
  end
endmodule